// File: doc/BRIEF.md
# IO Page Table Translation Walker

This block turns a 32-bit device virtual address into a physical address by reading a single page table entry from memory. A requester presents an address with a write flag. The walker first removes the bits that define the translation window. From the remaining bits and the table base it forms the address of the entry, and it fetches that entry through a request/grant read port. When the entry arrives, the walker answers with the physical address or with a fault.

Pages are 4 KB, and the 12 offset bits are carried through unchanged. The walker handles one translation at a time, and it takes a new request only while it is idle. When translation is switched off, the request is answered directly with the untranslated address, and the walker does not read memory.

Top module: `iopt_walker`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `rsp_done` and `mem_req` are 0.
- R2: The entry address on `mem_addr` is `(pt_base << 4) + ((masked >> 10) & ~3)`, computed modulo 2^32, where `masked = req_addr & ~win_start`.
- R3: Address bits that are set in `win_start` have no effect on the entry address.
- R4: For a usable entry, `rsp_paddr[30:12]` equals entry bits [26:8], `rsp_paddr[11:0]` equals `req_addr[11:0]`, and `rsp_paddr[31]` is 0.
- R5: An entry whose bit 1 (valid) is 0 gives `rsp_fault`=1 and `rsp_paddr`=0.
- R6: A write request that meets an entry with bit 2 (writable) at 0 gives a fault, with `rsp_paddr`=0. A read request that meets the same entry does not fault.
- R7: While `xlat_enable` is 0, an accepted request raises `rsp_done` in the next cycle, with `rsp_paddr` equal to `req_addr` and `rsp_fault` at 0. No memory read is issued.
- R8: `rsp_done` lasts exactly one cycle. `req_ready` is high only while the walker is idle, and a request presented while `req_ready` is low is not taken.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_gnt` is seen. `mem_rvalid` is ignored until the grant has been seen.
- R10: Entry bit 7 (cacheable) and bit 0 (write-as-zero) do not change the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 32 | Device virtual address |
| req_write | input | 1 | Request is a write |
| req_ready | output | 1 | Walker idle, request will be taken |
| xlat_enable | input | 1 | Translation on (0 = pass address through) |
| pt_base | input | 32 | Page table base register value |
| win_start | input | 32 | Translation window start mask |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 32 | Entry byte address |
| mem_gnt | input | 1 | Read request granted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Page table entry |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Translation fault |

## Verification
Two events can land in the same cycle: the one-cycle done strobe of one translation and the arrival of the next request. The bench holds a new request valid during the done cycle. It expects `req_ready` to be low in that cycle, the request to be taken one cycle later, and a second done that carries the new address. A second overlap comes from driving `mem_rvalid` with junk data during the cycles before the grant. The bench then checks that the response still reflects the entry delivered after the grant.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } walk_state_t;

  localparam int PTE_VALID_BIT = 1;
  localparam int PTE_WRITE_BIT = 2;
  localparam int PTE_PPN_LSB   = 8;
  localparam int PTE_PPN_MSB   = 26;
endpackage

// File: rtl/iopt_entry_addr.sv
module iopt_entry_addr #(
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_LOG2 = 2,
  parameter int BASE_SHIFT = 4
) (
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] win,
  output logic [AW-1:0] eaddr
);
  localparam int IDX_SHIFT = PAGE_SHIFT - ENTRY_LOG2;

  logic [AW-1:0] masked;
  logic [AW-1:0] shifted;
  logic [AW-1:0] index;

  assign masked  = vaddr & ~win;
  assign shifted = masked >> IDX_SHIFT;

  // entries are word aligned: clear the low index bits
  genvar gi;
  generate
    for (gi = 0; gi < AW; gi++) begin : g_idx
      if (gi < ENTRY_LOG2) begin : g_zero
        assign index[gi] = 1'b0;
      end else begin : g_keep
        assign index[gi] = shifted[gi];
      end
    end
  endgenerate

  assign eaddr = (base << BASE_SHIFT) + index;
endmodule

// File: rtl/iopt_entry_decode.sv
module iopt_entry_decode
  import iopt_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [31:0]   pte,
  input  logic [AW-1:0] vaddr,
  input  logic          is_write,
  output logic [AW-1:0] paddr,
  output logic          fault
);
  localparam int PPN_W = PTE_PPN_MSB - PTE_PPN_LSB + 1;

  logic [AW-1:0] raw;

  genvar gb;
  generate
    for (gb = 0; gb < AW; gb++) begin : g_pa
      if (gb < PAGE_SHIFT) begin : g_off
        assign raw[gb] = vaddr[gb];
      end else if (gb < PAGE_SHIFT + PPN_W) begin : g_ppn
        assign raw[gb] = pte[gb - PAGE_SHIFT + PTE_PPN_LSB];
      end else begin : g_hi
        assign raw[gb] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    fault = !pte[PTE_VALID_BIT] || (is_write && !pte[PTE_WRITE_BIT]);
    paddr = fault ? '0 : raw;
  end
endmodule

// File: rtl/iopt_seq.sv
module iopt_seq
  import iopt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          xlat_enable,
  input  logic [AW-1:0] eaddr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] dec_paddr,
  input  logic          dec_fault,
  output logic [AW-1:0] vaddr_q,
  output logic          write_q,
  output logic          req_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          rsp_done,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_fault
);
  walk_state_t   state_q;
  logic          mreq_q;
  logic [AW-1:0] maddr_q;
  logic [AW-1:0] paddr_q;
  logic          fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mreq_q  <= 1'b0;
      maddr_q <= '0;
      vaddr_q <= '0;
      write_q <= 1'b0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          vaddr_q <= req_addr;
          write_q <= req_write;
          if (xlat_enable) begin
            mreq_q  <= 1'b1;
            maddr_q <= eaddr;
            state_q <= ST_WAIT;
          end else begin
            paddr_q <= req_addr;
            fault_q <= 1'b0;
            state_q <= ST_RESP;
          end
        end
        ST_WAIT: begin
          if (mreq_q) begin
            if (mem_gnt) mreq_q <= 1'b0;
          end else if (mem_rvalid) begin
            paddr_q <= dec_paddr;
            fault_q <= dec_fault;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_done  = (state_q == ST_RESP);
  assign mem_req   = mreq_q;
  assign mem_addr  = maddr_q;
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  // R7
  bypass_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && !xlat_enable) |=> (rsp_done && !mem_req));

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_fault) |-> (rsp_paddr == '0));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker #(
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_LOG2 = 2,
  parameter int BASE_SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  output logic          req_ready,
  input  logic          xlat_enable,
  input  logic [AW-1:0] pt_base,
  input  logic [AW-1:0] win_start,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          rsp_done,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_fault
);
  logic [AW-1:0] eaddr;
  logic [AW-1:0] vaddr_q;
  logic          write_q;
  logic [AW-1:0] dec_paddr;
  logic          dec_fault;

  iopt_entry_addr #(
    .AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_LOG2(ENTRY_LOG2), .BASE_SHIFT(BASE_SHIFT)
  ) u_eaddr (
    .vaddr(req_addr),
    .base (pt_base),
    .win  (win_start),
    .eaddr(eaddr)
  );

  iopt_entry_decode #(
    .AW(AW), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_dec (
    .pte     (mem_rdata),
    .vaddr   (vaddr_q),
    .is_write(write_q),
    .paddr   (dec_paddr),
    .fault   (dec_fault)
  );

  iopt_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .xlat_enable(xlat_enable),
    .eaddr      (eaddr),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .dec_paddr  (dec_paddr),
    .dec_fault  (dec_fault),
    .vaddr_q    (vaddr_q),
    .write_q    (write_q),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .rsp_done   (rsp_done),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault)
  );
endmodule

// File: tb/sim_iopt_walker.sv
module sim_iopt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_ready;
  logic        xlat_enable = 1'b0;
  logic [31:0] pt_base = '0;
  logic [31:0] win_start = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iopt_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_ready(req_ready), .xlat_enable(xlat_enable),
    .pt_base(pt_base), .win_start(win_start), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rsp_done(rsp_done), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
  );

  function automatic logic [31:0] exp_eaddr(logic [31:0] va, logic [31:0] b, logic [31:0] w);
    return (b << 4) + (((va & ~w) >> 10) & ~32'h3);
  endfunction

  function automatic logic exp_fault(logic [31:0] pte, logic wr);
    return !pte[1] || (wr && !pte[2]);
  endfunction

  function automatic logic [31:0] exp_paddr(logic [31:0] va, logic [31:0] pte, logic wr);
    if (exp_fault(pte, wr)) return 32'h0;
    return ((pte & 32'h07FFFF00) << 4) | (va & 32'hFFF);
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic xact(logic [31:0] va, logic wr, logic en, logic [31:0] b,
                      logic [31:0] w, logic [31:0] pte, int gdly, int rdly);
    logic [31:0] ep;
    logic        ef;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b1; req_addr = va; req_write = wr; xlat_enable = en;
    pt_base = b; win_start = w;
    @(negedge clk);
    req_valid = 1'b0;
    if (!en) begin
      chk(rsp_done && !mem_req, "R7", {30'b0, rsp_done, mem_req}, 32'h2);
      chk(rsp_paddr == va && !rsp_fault, "R7", rsp_paddr, va);
    end else begin
      chk(mem_req && mem_addr == exp_eaddr(va, b, w), "R2", mem_addr, exp_eaddr(va, b, w));
      for (int i = 0; i < gdly; i++) begin
        mem_rvalid = 1'b1; mem_rdata = ~pte;
        @(negedge clk);
        chk(mem_req && mem_addr == exp_eaddr(va, b, w), "R9", mem_addr, exp_eaddr(va, b, w));
      end
      mem_rvalid = 1'b0; mem_gnt = 1'b1;
      @(negedge clk);
      mem_gnt = 1'b0;
      chk(!mem_req && !rsp_done, "R9", {30'b0, mem_req, rsp_done}, 32'h0);
      for (int i = 0; i < rdly; i++) @(negedge clk);
      mem_rvalid = 1'b1; mem_rdata = pte;
      @(negedge clk);
      mem_rvalid = 1'b0;
      ep = exp_paddr(va, pte, wr);
      ef = exp_fault(pte, wr);
      if (!pte[1])        chk(rsp_done && rsp_fault == ef && rsp_paddr == ep, "R5", rsp_paddr, ep);
      else if (ef)        chk(rsp_done && rsp_fault == ef && rsp_paddr == ep, "R6", rsp_paddr, ep);
      else                chk(rsp_done && rsp_fault == ef && rsp_paddr == ep, "R4", rsp_paddr, ep);
    end
    @(negedge clk);
    chk(!rsp_done && req_ready, "R8", {30'b0, rsp_done, req_ready}, 32'h1);
  endtask

  initial begin
    logic [31:0] va, b, w, pte, pte2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_done && !mem_req, "R1",
        {29'b0, req_ready, rsp_done, mem_req}, 32'h4);

    // R3 window bits do not reach the entry address
    xact(32'hFFFFF123, 1'b0, 1'b1, 32'h00100000, 32'hFF000000, 32'h00ABCD06, 1, 0);
    xact(32'h00FFF123, 1'b0, 1'b1, 32'h00100000, 32'hFF000000, 32'h00ABCD06, 0, 2);
    chk(exp_eaddr(32'hFFFFF123, 32'h00100000, 32'hFF000000) ==
        exp_eaddr(32'h00FFF123, 32'h00100000, 32'hFF000000), "R3", 32'h0, 32'h0);
    // R5 invalid entry, R6 write to read-only and read of same entry
    xact(32'h80012345, 1'b0, 1'b1, 32'h00004000, 32'h80000000, 32'h07FFFF04, 0, 0);
    xact(32'h80012345, 1'b1, 1'b1, 32'h00004000, 32'h80000000, 32'h07FFFF02, 2, 1);
    xact(32'h80012345, 1'b0, 1'b1, 32'h00004000, 32'h80000000, 32'h07FFFF02, 0, 1);
    // R10 cacheable and write-as-zero bits do not change the result
    xact(32'hC0345ABC, 1'b1, 1'b1, 32'h00020000, 32'hC0000000, 32'h01234506, 0, 0);
    xact(32'hC0345ABC, 1'b1, 1'b1, 32'h00020000, 32'hC0000000, 32'h01234587, 0, 0);
    chk(exp_paddr(32'hC0345ABC, 32'h01234587, 1'b1) == exp_paddr(32'hC0345ABC, 32'h01234506, 1'b1),
        "R10", 32'h0, 32'h0);
    // R7 bypass
    xact(32'hDEADBEEF, 1'b1, 1'b0, 32'h0, 32'hFF000000, 32'h0, 0, 0);

    // R8 new request presented in the done cycle
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h11112222; xlat_enable = 1'b0;
    @(negedge clk);
    chk(rsp_done && !req_ready, "R8", {30'b0, rsp_done, req_ready}, 32'h2);
    req_addr = 32'h33334444;
    @(negedge clk);
    chk(!rsp_done && req_ready, "R8", {30'b0, rsp_done, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_done && rsp_paddr == 32'h33334444, "R8", rsp_paddr, 32'h33334444);
    @(negedge clk);

    for (int n = 0; n < 200; n++) begin
      va   = $urandom;
      b    = $urandom & 32'h07FFFC00;
      w    = 32'hFFFFFFFF << (24 + ($urandom % 8));
      pte  = $urandom;
      if ($urandom % 4 != 0) pte[1] = 1'b1;
      pte2 = pte ^ 32'h81;
      xact(va, 1'($urandom), ($urandom % 6) != 0, b, w, (n % 2) ? pte2 : pte,
           $urandom % 3, $urandom % 3);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      misses++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule